// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave (I2C Block Protocol)

This block is the serial configuration port of a clock generator. It listens on a two-wire bus as a slave at the 7-bit address 0x69 and keeps six 8-bit configuration registers. It presents their contents as one flat parallel bus to the frequency-select and output-enable logic next to it. Both lines are brought into the system clock domain through two-flop synchronizers. The block drives SDA as an open-drain output: when `sda_oe` is high, the pad pulls SDA low.

A write transfer uses the address byte 0xD2. It carries two header bytes, a command code and then a byte count. The slave acknowledges both and discards them. The data bytes that follow fill the registers in rising order from index 0, and there is no random addressing. A stop after any whole byte ends the load. A read transfer uses the address byte 0xD3. The slave first returns a count byte of 6 and then the registers in index order, and the host acknowledges each byte. Only standard-mode timing is handled, and the slave never stretches the clock.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only if its upper seven bits equal 0x69 (0xD2 for a write, 0xD3 for a read). Any other address gets no acknowledge, and the slave then ignores the bus (no acknowledge, no register change) until the next start.
- R2: In a write, the two bytes that follow the address (command code, byte count) are each acknowledged and never change a register.
- R3: In a write, the data bytes after the header land in registers 0, 1, 2, ... in arrival order. Each byte is shifted MSB first, and register k appears on `cfg_o[8k+7:8k]`.
- R4: A stop after any complete data byte keeps the registers written so far and leaves every other register unchanged.
- R5: Data bytes after the sixth are acknowledged but not stored.
- R6: A read returns the byte 0x06 first, then registers 0 to 5 in order, each MSB first, as long as the host acknowledges. Past register 5 the slave sends 0xFF.
- R7: When the host does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next start.
- R8: After reset every register holds its default from the `DEFAULTS` parameter, and SDA is released.
- R9: A start (SDA falling while SCL is high) at any point, including a repeated start, restarts the address phase. A stop (SDA rising while SCL is high) returns the slave to idle with SDA released.
- R10: The slave changes its SDA drive only while SCL is low, so it never creates a start or stop of its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | 48 | Register k on bits [8k+7:8k] |

## Verification
The bench sweeps every foreign write address and checks the following:
- No acknowledge follows the address.
- A following 0xD2 byte is still not acknowledged, since a slave that re-armed on data would answer it.
- The registers stay unchanged.

It stops writes after each possible data count. A slave that cleared or shifted the untouched registers would show it there. It also overruns the six data bytes to catch wrap-around writes into register 0.

On reads it checks the following:
- The count byte and the byte order.
- That the slave stays silent after a NACK. It reads one more byte that would be non-0xFF if the slave kept sending.

A repeated start inside a write must restart the header count. A design that missed it would put the next data byte in the wrong register.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK,
        PH_IGNORE
    } phase_e;

endpackage

// File: rtl/clkcfg_i2c_sync.sv
module clkcfg_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sh_q, sda_sh_q;
    logic              scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sh_q <= {scl_sh_q[STAGES-2:0], scl_i};
            sda_sh_q <= {sda_sh_q[STAGES-2:0], sda_i};
            scl_p_q  <= scl_sh_q[STAGES-1];
            sda_p_q  <= sda_sh_q[STAGES-1];
        end
    end

    assign scl_o     = scl_sh_q[STAGES-1];
    assign sda_o     = sda_sh_q[STAGES-1];
    assign scl_rise  = scl_o & ~scl_p_q;
    assign scl_fall  = ~scl_o & scl_p_q;
    assign start_det = scl_o & scl_p_q & sda_p_q & ~sda_o;
    assign stop_det  = scl_o & scl_p_q & ~sda_p_q & sda_o;

endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank #(
    parameter int                    NUM_REGS = 6,
    parameter int                    IDXW     = 4,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDXW-1:0]       wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDXW-1:0]       rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_o
);

    logic [7:0] reg_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                reg_q[g] <= DEFAULTS[g*8 +: 8];
            else if (wr_en && wr_idx == IDXW'(g))
                reg_q[g] <= wr_data;
        end
        assign regs_o[g*8 +: 8] = reg_q[g];
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == IDXW'(i))
                rd_data = reg_q[i];
    end

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));  // R4

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter int                    NUM_REGS   = 6,
    parameter logic [6:0]            DEV_ADDR   = 7'h69,
    parameter int                    HDR_BYTES  = 2,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS   = 48'hA5_3C_FF_7E_F0_12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_o
);

    localparam int IDXW    = $clog2(NUM_REGS + HDR_BYTES + 1);
    localparam int CNT_MAX = NUM_REGS + HDR_BYTES;

    typedef struct packed {
        phase_e          phase;
        logic [3:0]      bitcnt;
        logic [7:0]      shreg;
        logic            is_addr;
        logic            rd_mode;
        logic [IDXW-1:0] cnt;
        logic            sda_oe;
        logic            host_ack;
    } state_t;

    state_t s_d, s_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx, rd_idx, data_idx;
    logic [7:0]      rd_data, tx_byte;

    clkcfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_o     (scl_s),
        .sda_o     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign rd_idx   = s_q.cnt - IDXW'(1);
    assign data_idx = s_q.cnt - IDXW'(HDR_BYTES);
    assign tx_byte  = (s_q.cnt == '0) ? 8'(NUM_REGS) : rd_data;

    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        wr_idx  = data_idx;
        if (stop_det) begin
            s_d.phase  = PH_IDLE;
            s_d.sda_oe = 1'b0;
        end else if (start_det) begin
            s_d.phase   = PH_RX;
            s_d.bitcnt  = '0;
            s_d.is_addr = 1'b1;
            s_d.rd_mode = 1'b0;
            s_d.cnt     = '0;
            s_d.sda_oe  = 1'b0;
        end else begin
            unique case (s_q.phase)
                PH_RX: begin
                    if (scl_rise && s_q.bitcnt != 4'd8) begin
                        s_d.shreg  = {s_q.shreg[6:0], sda_s};
                        s_d.bitcnt = s_q.bitcnt + 4'd1;
                    end else if (scl_fall && s_q.bitcnt == 4'd8) begin
                        if (s_q.is_addr) begin
                            if (s_q.shreg[7:1] == DEV_ADDR) begin
                                s_d.phase   = PH_RX_ACK;
                                s_d.sda_oe  = 1'b1;
                                s_d.rd_mode = s_q.shreg[0];
                                s_d.is_addr = 1'b0;
                                s_d.cnt     = '0;
                            end else begin
                                s_d.phase = PH_IGNORE;
                            end
                        end else begin
                            s_d.phase  = PH_RX_ACK;
                            s_d.sda_oe = 1'b1;
                            if (s_q.cnt >= IDXW'(HDR_BYTES) && data_idx < IDXW'(NUM_REGS))
                                wr_en = 1'b1;
                            if (s_q.cnt != IDXW'(CNT_MAX))
                                s_d.cnt = s_q.cnt + IDXW'(1);
                        end
                    end
                end
                PH_RX_ACK: begin
                    if (scl_fall) begin
                        s_d.bitcnt = '0;
                        if (s_q.rd_mode) begin
                            s_d.phase  = PH_TX;
                            s_d.shreg  = tx_byte;
                            s_d.sda_oe = ~tx_byte[7];
                            if (s_q.cnt != IDXW'(CNT_MAX))
                                s_d.cnt = s_q.cnt + IDXW'(1);
                        end else begin
                            s_d.phase  = PH_RX;
                            s_d.sda_oe = 1'b0;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (s_q.bitcnt == 4'd7) begin
                            s_d.phase  = PH_TX_ACK;
                            s_d.sda_oe = 1'b0;
                        end else begin
                            s_d.shreg  = {s_q.shreg[6:0], 1'b1};
                            s_d.bitcnt = s_q.bitcnt + 4'd1;
                            s_d.sda_oe = ~s_q.shreg[6];
                        end
                    end
                end
                PH_TX_ACK: begin
                    if (scl_rise) begin
                        s_d.host_ack = ~sda_s;
                    end else if (scl_fall) begin
                        if (s_q.host_ack) begin
                            s_d.phase  = PH_TX;
                            s_d.bitcnt = '0;
                            s_d.shreg  = tx_byte;
                            s_d.sda_oe = ~tx_byte[7];
                            if (s_q.cnt != IDXW'(CNT_MAX))
                                s_d.cnt = s_q.cnt + IDXW'(1);
                        end else begin
                            s_d.phase = PH_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.phase    <= PH_IDLE;
            s_q.shreg    <= 8'hFF;
        end else begin
            s_q <= s_d;
        end
    end

    clkcfg_regbank #(
        .NUM_REGS (NUM_REGS),
        .IDXW     (IDXW),
        .DEFAULTS (DEFAULTS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (s_q.shreg),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .regs_o  (cfg_o)
    );

    assign sda_oe = s_q.sda_oe;

    AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (s_d.sda_oe != s_q.sda_oe) |-> !scl_s);  // R10
    AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && s_q.phase == PH_IDLE));  // R9
    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (s_q.phase == PH_RX && s_q.is_addr && s_q.bitcnt == '0));  // R9
    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_IGNORE || s_q.phase == PH_IDLE) |-> !sda_oe);  // R1
    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDXW'(NUM_REGS) && !s_q.rd_mode));  // R5
    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bitcnt <= 4'd8);  // R3

endmodule

// File: tb/clkcfg_i2c_slave_tb.sv
`timescale 1ns/1ps
module clkcfg_i2c_slave_tb;

    localparam logic [47:0] DEF = 48'hA5_3C_FF_7E_F0_12;
    localparam int H = 16;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe;
    logic [47:0] cfg_o;
    wire  sda_line = sda_h & ~sda_oe;

    int tests = 0;
    int fails = 0;
    int r10_viol = 0;
    logic done = 1'b0;
    logic [7:0] expr [6];
    logic [7:0] wdata [10];

    always #2.5 clk = ~clk;

    clkcfg_i2c_slave #(.DEFAULTS(DEF)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_h),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .cfg_o  (cfg_o)
    );

    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (sda_oe !== prev_oe && scl_h) r10_viol++;
        prev_oe = sda_oe;
    end

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] packed_exp();
        logic [47:0] v;
        for (int i = 0; i < 6; i++) v[i*8 +: 8] = expr[i];
        return v;
    endfunction

    task automatic put_bit(input logic b);
        wc(Q); sda_h = b; wc(Q); scl_h = 1'b1; wc(H); scl_h = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wc(Q); sda_h = 1'b1; wc(Q); scl_h = 1'b1; wc(Q); b = sda_line; wc(Q); scl_h = 1'b0;
    endtask

    task automatic bus_start();
        wc(Q); sda_h = 1'b1; wc(Q); scl_h = 1'b1; wc(H); sda_h = 1'b0; wc(H); scl_h = 1'b0;
    endtask

    task automatic bus_stop();
        wc(Q); sda_h = 1'b0; wc(Q); scl_h = 1'b1; wc(H); sda_h = 1'b1; wc(H);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked);
        logic v;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(v);
        acked = ~v;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            get_bit(v);
            b[i] = v;
        end
        put_bit(~give_ack);
    endtask

    task automatic do_write(input int n);
        logic a;
        bus_start();
        write_byte(8'hD2, a);   chk("R1 write address ack", a, 1);
        write_byte(8'h5A, a);   chk("R2 command ack", a, 1);
        write_byte(8'h06, a);   chk("R2 byte count ack", a, 1);
        for (int i = 0; i < n; i++) begin
            write_byte(wdata[i], a);
            if (i < 6) begin
                chk("R3 data ack", a, 1);
                expr[i] = wdata[i];
            end else begin
                chk("R5 extra data ack", a, 1);
            end
        end
        bus_stop();
        wc(4);
    endtask

    task automatic do_read();
        logic [7:0] b;
        logic a;
        bus_start();
        write_byte(8'hD3, a);   chk("R1 read address ack", a, 1);
        read_byte(1'b1, b);     chk("R6 count byte", b, 8'h06);
        for (int i = 0; i < 6; i++) begin
            read_byte(i != 5, b);
            chk("R6 register byte", b, expr[i]);
        end
        bus_stop();
        wc(4);
    endtask

    function automatic logic [7:0] pat(input int p, input int i);
        return 8'((i + 1) * 37 + p * 91) ^ 8'(p << i);
    endfunction

    initial begin
        logic a;
        logic [7:0] b;
        for (int i = 0; i < 6; i++) expr[i] = DEF[i*8 +: 8];
        wc(5);
        rst_n = 1'b1;
        wc(5);
        chk("R8 reset defaults", cfg_o, DEF);
        chk("R8 sda released", sda_oe, 0);
        do_read();

        // R3 R6: several data patterns written then read back
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 6; i++) wdata[i] = pat(p, i);
            do_write(6);
            chk("R3 register contents", cfg_o, packed_exp());
            do_read();
        end

        // R4: stop after each possible data count
        for (int k = 1; k <= 5; k++) begin
            for (int i = 0; i < 6; i++) wdata[i] = 8'(8'hC0 + k * 16 + i);
            do_write(k);
            chk("R4 partial write", cfg_o, packed_exp());
        end

        // R5: overrun beyond six data bytes
        for (int i = 0; i < 8; i++) wdata[i] = 8'(8'h81 + i * 3);
        do_write(8);
        chk("R5 overrun not stored", cfg_o, packed_exp());

        // R7: NACK ends transmission
        for (int i = 0; i < 6; i++) wdata[i] = 8'(i * 8'h11);
        do_write(6);
        bus_start();
        write_byte(8'hD3, a);
        read_byte(1'b1, b);     chk("R6 count before NACK", b, 8'h06);
        read_byte(1'b0, b);     chk("R7 byte before NACK", b, expr[0]);
        read_byte(1'b0, b);     chk("R7 silent after NACK", b, 8'hFF);
        chk("R7 sda released", sda_oe, 0);
        bus_stop();

        // R9: repeated start inside a write restarts header count
        bus_start();
        write_byte(8'hD2, a); write_byte(8'h01, a); write_byte(8'h06, a);
        write_byte(8'h3C, a);
        expr[0] = 8'h3C;
        bus_start();
        write_byte(8'hD2, a);   chk("R9 address after repeated start", a, 1);
        write_byte(8'hE7, a);   write_byte(8'h99, a);
        write_byte(8'h4B, a);
        expr[0] = 8'h4B;
        bus_stop();
        wc(4);
        chk("R9 repeated start header", cfg_o, packed_exp());
        bus_start();
        write_byte(8'hD2, a); write_byte(8'h00, a);
        bus_start();
        write_byte(8'hD3, a);   chk("R9 read after repeated start", a, 1);
        read_byte(1'b0, b);     chk("R9 count after repeated start", b, 8'h06);
        bus_stop();
        wc(4);

        // R1: sweep every foreign write address
        for (int ad = 0; ad < 128; ad++) begin
            logic a2;
            if (ad == 'h69) continue;
            bus_start();
            write_byte({7'(ad), 1'b0}, a);
            write_byte(8'hD2, a2);
            bus_stop();
            wc(2);
            chk("R1 foreign address ignored", {a, a2, cfg_o}, {2'b00, packed_exp()});
        end

        chk("R10 drive changes only with SCL low", r10_viol, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule